// File: doc/BRIEF.md
# Compressed Audio Frame Sync Tracker

This block sits at the input of a compressed multichannel audio path. It receives a serial bitstream from a demultiplexer as a data line qualified by an active-low valid line, both sampled on the rising edge of the block clock, which is the interface bit clock. It searches the stream for the 16-bit frame sync word. From the header that follows it works out the frame length, and it then confirms sync at each following frame boundary. It declares lock, reports a missed boundary, and after repeated misses drops lock and raises a request for the host to restart acquisition.

The host restarts acquisition by pulsing a sync-cancel input. While cancel is high the tracker is held unlocked and does not search. The search begins again once cancel is released. The first header fields of each confirmed frame are captured into status outputs. A sticky error bit flags unsupported version numbers and reserved or invalid rate and size codes. An active-low data-request output throttles the sender: it is driven from an internal byte-occupancy count, which rises as bytes arrive and falls as the downstream stage takes them.

Top module: `aud_frame_sync_tracker`

## Requirements
- R1: During and after a synchronous reset: stat_nolock=1, stat_nodet=1, stat_err=0, resync_req=0, req_n=0 and all header outputs zero.
- R2: A bit is accepted only on a rising edge with ser_valid_n=0. Cycles with ser_valid_n=1 neither shift data nor advance the frame position, whatever ser_data carries.
- R3: Search runs bit by bit for the word 0x0B77, sent MSB first. The first match starts a candidate frame without declaring lock. Bits 32..47 of a frame are captured one cycle after bit 47 as hdr_rate=bits 32..33, hdr_size=bits 34..39, hdr_ver=bits 40..44 and hdr_svc=bits 45..47, each MSB first. Capture happens only for frames whose sync word was seen.
- R4: Frame length is 16 bits per word. The bit rate in kbps is indexed by hdr_size[5:1] from the list 32,40,48,56,64,80,96,112,128,160,192,224,256,320,384,448,512,576,640. Words per frame are 2*kbps for rate code 00 (48 kHz), 3*kbps for rate code 10 (32 kHz), and floor(kbps*320/147)+hdr_size[0] for rate code 01 (44.1 kHz).
- R5: When a second sync word ends exactly one frame length after the candidate's, stat_nolock and stat_nodet both read 0 one cycle after its last bit.
- R6: While locked, a sync word missing at the expected boundary sets stat_nodet=1 and keeps lock. A sync word found there sets stat_nodet=0.
- R7: Two consecutive boundary misses while locked set stat_nolock=1 and resync_req=1. Both hold, with no new search, until sync_cancel is asserted.
- R8: While sync_cancel=1 the tracker is unlocked, does not search, and drives resync_req=0, stat_nodet=1 and stat_err=0. Search resumes once sync_cancel returns to 0.
- R9: A captured version field above 8 sets stat_err, which stays set until sync_cancel or reset. Versions 0 to 8 leave it unchanged and do not prevent lock.
- R10: A captured rate code of 11 or a size code above 37 sets stat_err. In a candidate frame it returns the tracker to search, so lock needs two further good frames.
- R11: Each eighth accepted bit adds one byte to an occupancy count, up to FILL_DEPTH (default 128). Each cycle with byte_take=1 and a nonzero count removes one byte. req_n=1 exactly when the count is at or above FILL_HWM (default 64), and it follows the count with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface bit clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial bitstream, MSB of each word first |
| ser_valid_n | input | 1 | Active-low qualifier for ser_data |
| sync_cancel | input | 1 | Clears lock; search restarts when released |
| byte_take | input | 1 | Downstream removes one byte from occupancy |
| req_n | output | 1 | Active-low data request to the sender |
| resync_req | output | 1 | Sync lost; asks host to pulse sync_cancel |
| stat_nolock | output | 1 | 0 when locked, 1 when unlocked |
| stat_nodet | output | 1 | 0 when last boundary held a sync word |
| stat_err | output | 1 | Sticky header error |
| hdr_rate | output | 2 | Captured sample-rate code |
| hdr_size | output | 6 | Captured frame-size code |
| hdr_ver | output | 5 | Captured version field |
| hdr_svc | output | 3 | Captured service-type field |

## Verification
Every status and header result is registered once. It therefore appears one clock after the accepted bit that causes it: bit 15 of a frame for the boundary verdicts, bit 47 for the header, the cancel cycle for the clear. req_n is decoded from the occupancy register, so it too moves one clock after the bit that completes a byte or the cycle that takes one. The driver stamps each expected item with the cycle number one past the edge that consumes its stimulus. The monitor compares items only at the falling edge of that exact cycle and counts any item found late as a failure.

// File: rtl/aud_sync_pkg.sv
// Shared constants, types and rate arithmetic for the frame sync tracker.
// Assumes headers are sent MSB first and the frame size code is 6 bits.
package aud_sync_pkg;

    localparam logic [15:0] SYNC_WORD = 16'h0B77;
    localparam int          HDR_POS   = 47;   // last bit of the captured header word
    localparam int          SYNC_POS  = 15;   // last bit of the sync word
    localparam logic [5:0]  SIZE_MAX  = 6'd37;
    localparam logic [4:0]  VER_MAX   = 5'd8;

    typedef enum logic [2:0] {
        ST_SEARCH,
        ST_CAND,
        ST_LOCK,
        ST_LOST,
        ST_HOLD
    } trk_state_t;

    typedef struct packed {
        logic [1:0] rate;
        logic [5:0] size;
        logic [4:0] ver;
        logic [2:0] svc;
    } hdr_t;

    // Nominal bit rate in kbps for a frame size pair index
    function automatic logic [9:0] rate_kbps(input logic [4:0] idx);
        logic [9:0] r;
        case (idx)
            5'd0:  r = 10'd32;
            5'd1:  r = 10'd40;
            5'd2:  r = 10'd48;
            5'd3:  r = 10'd56;
            5'd4:  r = 10'd64;
            5'd5:  r = 10'd80;
            5'd6:  r = 10'd96;
            5'd7:  r = 10'd112;
            5'd8:  r = 10'd128;
            5'd9:  r = 10'd160;
            5'd10: r = 10'd192;
            5'd11: r = 10'd224;
            5'd12: r = 10'd256;
            5'd13: r = 10'd320;
            5'd14: r = 10'd384;
            5'd15: r = 10'd448;
            5'd16: r = 10'd512;
            5'd17: r = 10'd576;
            5'd18: r = 10'd640;
            default: r = 10'd0;
        endcase
        return r;
    endfunction

    // 16-bit words per frame for a rate code and a size code
    function automatic logic [10:0] frame_words(input logic [1:0] rate, input logic [5:0] size);
        logic [17:0] kb;
        logic [17:0] w;
        kb = {8'd0, rate_kbps(size[5:1])};
        case (rate)
            2'b00:   w = kb * 18'd2;
            2'b10:   w = kb * 18'd3;
            2'b01:   w = (kb * 18'd320) / 18'd147 + {17'd0, size[0]};
            default: w = 18'd0;
        endcase
        return w[10:0];
    endfunction

endpackage

// File: rtl/aud_bit_window.sv
// Sliding window over the accepted serial bits.
// Shifts only on accepted bits; exposes the window including the current bit.
module aud_bit_window #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic [WIN_W-1:0] win_next
);

    logic [WIN_W-1:0] win_q;

    // Window as it stands once the present bit is included
    always_comb win_next = {win_q[WIN_W-2:0], bit_in};

    // Hold the last WIN_W accepted bits
    always_ff @(posedge clk) begin
        if (!rst_n)      win_q <= '0;
        else if (bit_en) win_q <= win_next;
    end

endmodule

// File: rtl/aud_frame_len.sv
// Combinational header decode: frame length in bits and header validity.
// Assumes the header word is presented as rate, size, version, service.
module aud_frame_len
    import aud_sync_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  hdr_t             hdr,
    output logic [LEN_W-1:0] len_bits,
    output logic             hdr_bad,
    output logic             ver_bad
);

    localparam int WORD_SHIFT = 4;

    logic [10:0] words;

    // Words per frame from the rate and size codes
    always_comb words = frame_words(hdr.rate, hdr.size);

    // Length in bits and header checks
    always_comb begin
        len_bits = LEN_W'({words, {WORD_SHIFT{1'b0}}});
        hdr_bad  = (hdr.rate == 2'b11) || (hdr.size > SIZE_MAX);
        ver_bad  = (hdr.ver > VER_MAX);
    end

endmodule

// File: rtl/aud_lock_fsm.sv
// Sync acquisition and tracking state machine.
// Counts accepted bits within a frame, checks the sync word at each boundary,
// captures the header of frames whose sync was seen, and handles cancel.
module aud_lock_fsm
    import aud_sync_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             cancel,
    input  logic [15:0]      win_next,
    input  logic [LEN_W-1:0] len_new,
    input  logic             hdr_bad,
    input  logic             ver_bad,
    output logic             locked_n,
    output logic             nodet,
    output logic             err,
    output logic             resync,
    output hdr_t             hdr_q
);

    trk_state_t       state;
    logic [LEN_W-1:0] pos;
    logic [LEN_W-1:0] len_q;
    logic             miss1;
    logic             hitf;
    logic             sync_hit;
    logic             at_end;
    logic             at_sync;
    logic             at_hdr;

    // Boundary and header position decode
    always_comb begin
        sync_hit = (win_next == SYNC_WORD);
        at_end   = (pos == len_q - LEN_W'(1));
        at_sync  = (pos == LEN_W'(SYNC_POS));
        at_hdr   = (pos == LEN_W'(HDR_POS));
    end

    // State, position, status and header capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SEARCH;
            pos   <= '0;
            len_q <= '0;
            miss1 <= 1'b0;
            hitf  <= 1'b0;
            nodet <= 1'b1;
            err   <= 1'b0;
            hdr_q <= '0;
        end else if (cancel) begin
            state <= ST_HOLD;
            pos   <= '0;
            miss1 <= 1'b0;
            hitf  <= 1'b0;
            nodet <= 1'b1;
            err   <= 1'b0;
        end else begin
            unique case (state)
                ST_HOLD: state <= ST_SEARCH;
                ST_LOST: state <= ST_LOST;
                ST_SEARCH: begin
                    if (bit_en && sync_hit) begin
                        state <= ST_CAND;
                        pos   <= LEN_W'(SYNC_POS + 1);
                        hitf  <= 1'b1;
                        miss1 <= 1'b0;
                    end
                end
                default: begin
                    if (bit_en) begin
                        pos <= at_end ? '0 : pos + LEN_W'(1);
                        if (at_sync) begin
                            if (sync_hit) begin
                                state <= ST_LOCK;
                                nodet <= 1'b0;
                                hitf  <= 1'b1;
                                miss1 <= 1'b0;
                            end else begin
                                nodet <= 1'b1;
                                hitf  <= 1'b0;
                                if (state == ST_CAND) state <= ST_SEARCH;
                                else if (miss1)       state <= ST_LOST;
                                else                  miss1 <= 1'b1;
                            end
                        end
                        if (at_hdr && hitf) begin
                            hdr_q <= hdr_t'(win_next);
                            if (hdr_bad) begin
                                err <= 1'b1;
                                if (state == ST_CAND) state <= ST_SEARCH;
                            end else begin
                                len_q <= len_new;
                                if (ver_bad) err <= 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // Status decode from the state register
    always_comb begin
        locked_n = (state != ST_LOCK);
        resync   = (state == ST_LOST);
    end

endmodule

// File: rtl/aud_fill_ctr.sv
// Byte occupancy of the input buffer and the active-low data request.
// Assumes one byte is formed from every eight accepted bits.
module aud_fill_ctr #(
    parameter int DEPTH = 128,
    parameter int HWM   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic take,
    output logic req_n
);

    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [2:0]        phase;
    logic [FILL_W-1:0] fill;
    logic              inc;
    logic              dec;

    // Byte completion and removal strobes
    always_comb begin
        inc = bit_en && (phase == 3'd7) && (fill < FILL_W'(DEPTH));
        dec = take && (fill != '0);
    end

    // Bit phase within the current byte
    always_ff @(posedge clk) begin
        if (!rst_n)      phase <= '0;
        else if (bit_en) phase <= phase + 3'd1;
    end

    // Occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n) fill <= '0;
        else if (inc && !dec) fill <= fill + FILL_W'(1);
        else if (dec && !inc) fill <= fill - FILL_W'(1);
    end

    // Request off at or above the high-water mark
    always_comb req_n = (fill >= FILL_W'(HWM));

endmodule

// File: rtl/aud_frame_sync_tracker.sv
// Top of the compressed audio frame sync tracker.
// Single clock domain: the block clock is the serial interface clock.
module aud_frame_sync_tracker
    import aud_sync_pkg::*;
#(
    parameter int FILL_DEPTH = 128,
    parameter int FILL_HWM   = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_data,
    input  logic       ser_valid_n,
    input  logic       sync_cancel,
    input  logic       byte_take,
    output logic       req_n,
    output logic       resync_req,
    output logic       stat_nolock,
    output logic       stat_nodet,
    output logic       stat_err,
    output logic [1:0] hdr_rate,
    output logic [5:0] hdr_size,
    output logic [4:0] hdr_ver,
    output logic [2:0] hdr_svc
);

    localparam int WIN_W = 16;
    localparam int LEN_W = 16;

    logic             bit_en;
    logic [WIN_W-1:0] win_next;
    logic [LEN_W-1:0] len_new;
    logic             hdr_bad;
    logic             ver_bad;
    hdr_t             hdr_q;

    // Accept a bit only while the valid line is low
    always_comb bit_en = !ser_valid_n;

    aud_bit_window #(.WIN_W(WIN_W)) i_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (ser_data),
        .win_next (win_next)
    );

    aud_frame_len #(.LEN_W(LEN_W)) i_len (
        .hdr      (hdr_t'(win_next)),
        .len_bits (len_new),
        .hdr_bad  (hdr_bad),
        .ver_bad  (ver_bad)
    );

    aud_lock_fsm #(.LEN_W(LEN_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .cancel   (sync_cancel),
        .win_next (win_next),
        .len_new  (len_new),
        .hdr_bad  (hdr_bad),
        .ver_bad  (ver_bad),
        .locked_n (stat_nolock),
        .nodet    (stat_nodet),
        .err      (stat_err),
        .resync   (resync_req),
        .hdr_q    (hdr_q)
    );

    aud_fill_ctr #(.DEPTH(FILL_DEPTH), .HWM(FILL_HWM)) i_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .take   (byte_take),
        .req_n  (req_n)
    );

    // Header fields to the status outputs
    always_comb begin
        hdr_rate = hdr_q.rate;
        hdr_size = hdr_q.size;
        hdr_ver  = hdr_q.ver;
        hdr_svc  = hdr_q.svc;
    end

endmodule

// File: rtl/aud_sync_chk.sv
// Protocol checker for the frame sync tracker, attached by bind.
module aud_sync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ser_data,
    input logic       ser_valid_n,
    input logic       sync_cancel,
    input logic       byte_take,
    input logic       req_n,
    input logic       resync_req,
    input logic       stat_nolock,
    input logic       stat_nodet,
    input logic       stat_err,
    input logic [1:0] hdr_rate,
    input logic [5:0] hdr_size,
    input logic [4:0] hdr_ver,
    input logic [2:0] hdr_svc
);

    // R8
    cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_cancel |=> (stat_nolock && !resync_req && stat_nodet && !stat_err));

    // R2
    idle_holds_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid_n && !sync_cancel) |=> ($stable(stat_nodet) && $stable(stat_nolock)
            && $stable({hdr_rate, hdr_size, hdr_ver, hdr_svc})));

    // R5
    lock_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_nolock) |-> $past(!ser_valid_n));

    // R7
    lost_from_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resync_req) |-> $past(!stat_nolock));

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_err) |-> $past(sync_cancel));

    // R11
    req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_n) |-> $past(!ser_valid_n));

    // R11
    req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> $past(byte_take));

endmodule

bind aud_frame_sync_tracker aud_sync_chk i_chk (.*);

// File: tb/test_aud_frame_sync_tracker.sv
module test_aud_frame_sync_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int HWM        = 64;
    localparam int DEPTH      = 128;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_valid_n = 1'b1;
    logic       sync_cancel = 1'b0;
    logic       byte_take = 1'b1;
    logic       req_n;
    logic       resync_req;
    logic       stat_nolock;
    logic       stat_nodet;
    logic       stat_err;
    logic [1:0] hdr_rate;
    logic [5:0] hdr_size;
    logic [4:0] hdr_ver;
    logic [2:0] hdr_svc;

    aud_frame_sync_tracker i_aud_frame_sync_tracker (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int          due;
        int          sel;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Bench-side model state
    int    fill_m = 0;
    int    phase_m = 0;
    bit    take_mode = 1'b1;
    bit    cancel_mode = 1'b0;

    localparam int SEL_NOLOCK = 0, SEL_NODET = 1, SEL_ERR = 2, SEL_RESYNC = 3,
                   SEL_REQ = 4, SEL_HDR = 5;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] actual(input int sel);
        case (sel)
            SEL_NOLOCK: return {15'd0, stat_nolock};
            SEL_NODET:  return {15'd0, stat_nodet};
            SEL_ERR:    return {15'd0, stat_err};
            SEL_RESYNC: return {15'd0, resync_req};
            SEL_REQ:    return {15'd0, req_n};
            default:    return {hdr_rate, hdr_size, hdr_ver, hdr_svc};
        endcase
    endfunction

    task automatic expect_at(input int sel, input logic [15:0] v, input string tag);
        item_t it;
        it.due = cyc + 1;
        it.sel = sel;
        it.exp = v;
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare every item due in this cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [15:0] a;
            it = q.pop_front();
            a = actual(it.sel);
            n_run++;
            if (it.due != cyc || a !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h",
                         it.tag, it.sel, cyc, a, it.exp);
            end
        end
    end

    // Rule-based frame length in bits
    function automatic int frame_bits(input logic [1:0] rate, input logic [5:0] size);
        int kb;
        int w;
        int list [19] = '{32, 40, 48, 56, 64, 80, 96, 112, 128, 160, 192, 224,
                           256, 320, 384, 448, 512, 576, 640};
        kb = list[size[5:1]];
        if (rate == 2'b00)      w = 2 * kb;
        else if (rate == 2'b10) w = 3 * kb;
        else                    w = (kb * 320) / 147 + size[0];
        return w * 16;
    endfunction

    function automatic logic [15:0] hw(input logic [1:0] r, input logic [5:0] s,
                                       input logic [4:0] v, input logic [2:0] m);
        return {r, s, v, m};
    endfunction

    // Driver: one bit per cycle, with the occupancy model (R11)
    task automatic drive_bit(input logic d, input logic vn);
        bit inc;
        bit dec;
        @(negedge clk);
        ser_data    = d;
        ser_valid_n = vn;
        byte_take   = take_mode;
        sync_cancel = cancel_mode;
        inc = (!vn && phase_m == 7 && fill_m < DEPTH);
        dec = (take_mode && fill_m != 0);
        if (!vn) phase_m = (phase_m + 1) % 8;
        fill_m = fill_m + (inc ? 1 : 0) - (dec ? 1 : 0);
        expect_at(SEL_REQ, {15'd0, fill_m >= HWM}, "R11");
    endtask

    task automatic send_frame(input logic [15:0] syncw, input logic [15:0] h, input int nbits,
                              input int gap, input bit c15, input logic e_nolock,
                              input logic e_nodet, input logic e_resync, input string t15,
                              input bit c47, input logic e_err, input string t47);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            if (i < 16)                b = syncw[15-i];
            else if (i >= 32 && i < 48) b = h[47-i];
            else                       b = 1'b0;
            if (gap != 0 && (i % gap) == 5) drive_bit(1'b1, 1'b1);
            drive_bit(b, 1'b0);
            if (c15 && i == 15) begin
                expect_at(SEL_NOLOCK, {15'd0, e_nolock}, t15);
                expect_at(SEL_NODET,  {15'd0, e_nodet},  t15);
                expect_at(SEL_RESYNC, {15'd0, e_resync}, t15);
            end
            if (c47 && i == 47) begin
                expect_at(SEL_HDR, h, t47);
                expect_at(SEL_ERR, {15'd0, e_err}, t47);
            end
        end
    endtask

    task automatic do_cancel(input int n);
        cancel_mode = 1'b1;
        for (int i = 0; i < n; i++) drive_bit(1'b0, 1'b1);
        expect_at(SEL_NOLOCK, 16'd1, "R8");
        expect_at(SEL_RESYNC, 16'd0, "R8");
        expect_at(SEL_NODET,  16'd1, "R8");
        expect_at(SEL_ERR,    16'd0, "R8");
        cancel_mode = 1'b0;
        drive_bit(1'b0, 1'b1);
        drive_bit(1'b0, 1'b1);
    endtask

    localparam logic [15:0] SW = 16'h0B77;

    initial begin
        logic [15:0] h_ok, h_v9, h_r3, h_s40, h_44, h_32;
        int f48, f44, f32;
        h_ok  = hw(2'b00, 6'd0,  5'd8, 3'd3);
        h_v9  = hw(2'b00, 6'd0,  5'd9, 3'd1);
        h_r3  = hw(2'b11, 6'd0,  5'd8, 3'd3);
        h_s40 = hw(2'b00, 6'd40, 5'd8, 3'd3);
        h_44  = hw(2'b01, 6'd1,  5'd6, 3'd2);
        h_32  = hw(2'b10, 6'd0,  5'd4, 3'd0);
        f48 = frame_bits(2'b00, 6'd0);
        f44 = frame_bits(2'b01, 6'd1);
        f32 = frame_bits(2'b10, 6'd0);

        // R1: reset values
        repeat (3) @(negedge clk);
        expect_at(SEL_NOLOCK, 16'd1, "R1");
        expect_at(SEL_NODET,  16'd1, "R1");
        expect_at(SEL_ERR,    16'd0, "R1");
        expect_at(SEL_RESYNC, 16'd0, "R1");
        expect_at(SEL_REQ,    16'd0, "R1");
        expect_at(SEL_HDR,    16'd0, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 20; i++) drive_bit(1'b0, 1'b0);
        // R3: candidate only, header capture; R9: version 8 accepted
        send_frame(SW, h_ok, f48, 0, 1, 1, 1, 0, "R3", 1, 0, "R3_R9");
        // R5: second sync one frame later locks
        send_frame(SW, h_ok, f48, 0, 1, 0, 0, 0, "R5", 1, 0, "R3");
        // R2: invalid cycles with garbage inside frames leave positions intact
        send_frame(SW, h_ok, f48, 7, 1, 0, 0, 0, "R2", 1, 0, "R2");
        send_frame(SW, h_ok, f48, 3, 1, 0, 0, 0, "R2", 0, 0, "");
        // R6: single miss keeps lock, then recovery
        send_frame(16'h0000, h_ok, f48, 0, 1, 0, 1, 0, "R6", 0, 0, "");
        send_frame(SW, h_ok, f48, 0, 1, 0, 0, 0, "R6", 0, 0, "");
        // R7: two misses drop lock and raise the request
        send_frame(16'h0000, h_ok, f48, 0, 1, 0, 1, 0, "R6", 0, 0, "");
        send_frame(16'h0000, h_ok, f48, 0, 1, 1, 1, 1, "R7", 0, 0, "");
        send_frame(SW, h_ok, f48, 0, 1, 1, 1, 1, "R7", 0, 0, "");
        // R8: cancel and restart
        do_cancel(3);
        // R9: version 9 sets sticky error, lock still reached
        send_frame(SW, h_v9, f48, 0, 1, 1, 1, 0, "R8", 1, 1, "R9");
        send_frame(SW, h_ok, f48, 0, 1, 0, 0, 0, "R9", 1, 1, "R9");
        do_cancel(1);
        // R10: reserved rate returns to search
        send_frame(SW, h_r3, f48, 0, 1, 1, 1, 0, "R10", 1, 1, "R10");
        send_frame(SW, h_ok, f48, 0, 1, 1, 1, 0, "R10", 1, 1, "R10");
        send_frame(SW, h_ok, f48, 0, 1, 0, 0, 0, "R10", 0, 0, "");
        do_cancel(2);
        // R10: size code above 37
        send_frame(SW, h_s40, f48, 0, 1, 1, 1, 0, "R10", 1, 1, "R10");
        send_frame(SW, h_ok, f48, 0, 1, 1, 1, 0, "R10", 1, 1, "R10");
        do_cancel(2);
        // R4: 44.1 kHz length with odd size code
        send_frame(SW, h_44, f44, 0, 1, 1, 1, 0, "R4", 1, 0, "R4");
        send_frame(SW, h_44, f44, 0, 1, 0, 0, 0, "R4", 0, 0, "");
        do_cancel(2);
        // R4: 32 kHz length
        send_frame(SW, h_32, f32, 0, 1, 1, 1, 0, "R4", 1, 0, "R4");
        send_frame(SW, h_32, f32, 0, 1, 0, 0, 0, "R4", 0, 0, "");
        // R11: fill above the high-water mark, then drain
        take_mode = 1'b0;
        for (int i = 0; i < 600; i++) drive_bit(1'b0, 1'b0);
        take_mode = 1'b1;
        for (int i = 0; i < 100; i++) drive_bit(1'b1, 1'b1);
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        if (!done && cyc > WATCHDOG) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d actual=running expected=finished", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule